// File: doc/BRIEF.md
# Kernel Segment Address Translator

This block sits in front of the memory system and examines every 32-bit virtual address by its top nibble. That nibble selects one of sixteen 256 MB segments. Each segment is configured in one of two ways. A linear segment replaces the top nibble with a 4-bit base taken from configuration. A paged segment produces no physical address and raises a request for a page-table walk instead. A privilege input restricts user-mode accesses to the lower segments. Accesses outside that range are reported as faults.

Lookups use a valid/ready handshake. A request that is accepted on a clock edge has its result registered one cycle later. Configuration arrives through a small write port that selects one of three registers. A write has priority over a lookup in the same cycle. At reset the block acts as an identity map. This lets code that runs before configuration, for example code in the segment at 0x4xxxxxxx, go on working unchanged.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `out_valid` is 0. Every segment is linear with a base equal to its own index, so an accepted kernel address comes back unchanged.
- R2: `req_ready` equals the inverse of `cfg_we`. A request is accepted when `req_valid` and `req_ready` are both 1. Its result appears with `out_valid`=1 in the cycle after acceptance. `out_valid` is 1 only in cycles that follow an acceptance.
- R3: For a linear segment with no fault, `out_paddr` = {base nibble, `req_vaddr[27:0]`}, and `out_walk` and `out_fault` are both 0.
- R4: For a paged segment with no fault, `out_walk` is 1, `out_paddr` is 0 and `out_uncached` is 0. For every accepted request, `out_vaddr` echoes the full virtual address.
- R5: When `req_user` is 1 and the segment index is 0xB or higher, `out_fault` is 1, `out_walk` is 0 and `out_paddr` is 0. When `req_user` is 0, no fault is raised.
- R6: A write with `cfg_sel`=0 loads the mode bits: bit i belongs to segment i, and 1 means paged. `cfg_sel`=1 loads the bases of segments 0..7, with segment i in bits 4i+3:4i. `cfg_sel`=2 loads the bases of segments 8..15, with segment i in bits 4(i-8)+3:4(i-8). The new values apply to requests accepted in any later cycle.
- R7: `out_uncached` equals bit 31 of the translated address on a linear hit, which means a base of 0x8..0xF. It is 0 for walks and faults.
- R8: A request presented while `cfg_we` is 1 is not accepted and produces no result in the following cycle.
- R9: A write with `cfg_sel`=3 changes no mode bit and no base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_user | input | 1 | 1 = user-mode access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 low bases, 2 high bases, 3 reserved |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Result of an accepted lookup |
| out_paddr | output | 32 | Physical address (0 unless linear hit) |
| out_uncached | output | 1 | Uncached attribute of the physical address |
| out_walk | output | 1 | Page-walk request for a paged segment |
| out_fault | output | 1 | Privilege fault |
| out_vaddr | output | 32 | Virtual address of the accepted lookup |

## Verification
The assertions assume that `req_vaddr` and `req_user` hold known values whenever `req_valid` is 1. They also assume that `cfg_sel` is known whenever `cfg_we` is 1. The stimulus changes inputs only on falling edges and sets every input on each drive, so no unknown value reaches an edge. It covers every segment in both privilege modes. It also covers writes that collide with requests, reserved-select writes, and back-to-back lookups separated by idle cycles.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    CFG_MODE    = 2'd0,
    CFG_BASE_LO = 2'd1,
    CFG_BASE_HI = 2'd2,
    CFG_RSVD    = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
  parameter int SEG_BITS = 4,
  parameter int DATA_W   = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [1:0]                           cfg_sel,
  input  logic [DATA_W-1:0]                    cfg_wdata,
  output logic [(1<<SEG_BITS)-1:0]             mode_o,
  output logic [(1<<SEG_BITS)-1:0][SEG_BITS-1:0] base_o
);
  import seg_xlate_pkg::*;
  localparam int NSEG = 1 << SEG_BITS;
  localparam int SPW  = DATA_W / SEG_BITS;

  logic [NSEG-1:0]               mode_q, mode_d;
  logic [NSEG-1:0][SEG_BITS-1:0] base_q, base_d;
  logic                          mode_en;

  assign mode_en = cfg_we && (cfg_sel == CFG_MODE);

  always_comb begin
    mode_d = mode_q;
    if (mode_en) mode_d = cfg_wdata[NSEG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_base
    localparam int GI   = 1 + i / SPW;
    localparam int LANE = i % SPW;
    logic en;
    assign en = cfg_we && (cfg_sel == GI[1:0]);
    always_comb begin
      base_d[i] = base_q[i];
      if (en) base_d[i] = cfg_wdata[LANE*SEG_BITS +: SEG_BITS];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  base_q[i] <= SEG_BITS'(i);
      else if (en) base_q[i] <= base_d[i];
    end
  end

  assign mode_o = mode_q;
  assign base_o = base_q;

  // R9
  rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == CFG_RSVD) |=> ($stable(mode_q) && $stable(base_q)));
endmodule

// File: rtl/seg_decode.sv
module seg_decode #(
  parameter int ADDR_W         = 32,
  parameter int SEG_BITS       = 4,
  parameter int USER_SEG_LIMIT = 11
) (
  input  logic [ADDR_W-1:0]                      vaddr,
  input  logic                                   user,
  input  logic [(1<<SEG_BITS)-1:0]               mode,
  input  logic [(1<<SEG_BITS)-1:0][SEG_BITS-1:0] base,
  output logic [ADDR_W-1:0]                      paddr,
  output logic                                   uncached,
  output logic                                   walk,
  output logic                                   fault
);
  localparam int OFF_W = ADDR_W - SEG_BITS;

  logic [SEG_BITS-1:0] seg;
  logic                linear;

  assign seg = vaddr[ADDR_W-1:OFF_W];

  always_comb begin
    fault    = user && (int'(seg) >= USER_SEG_LIMIT);
    walk     = !fault && mode[seg];
    linear   = !fault && !mode[seg];
    paddr    = '0;
    uncached = 1'b0;
    if (linear) begin
      paddr    = {base[seg], vaddr[OFF_W-1:0]};
      uncached = base[seg][SEG_BITS-1];
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ADDR_W         = 32,
  parameter int SEG_BITS       = 4,
  parameter int USER_SEG_LIMIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_user,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_paddr,
  output logic              out_uncached,
  output logic              out_walk,
  output logic              out_fault,
  output logic [ADDR_W-1:0] out_vaddr
);
  localparam int NSEG  = 1 << SEG_BITS;
  localparam int OFF_W = ADDR_W - SEG_BITS;

  logic [NSEG-1:0]               mode;
  logic [NSEG-1:0][SEG_BITS-1:0] base;
  logic [ADDR_W-1:0]             dec_paddr;
  logic                          dec_unc, dec_walk, dec_fault;
  logic                          accept;

  seg_cfg_regs #(.SEG_BITS(SEG_BITS), .DATA_W(32)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mode_o(mode), .base_o(base)
  );

  seg_decode #(.ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS),
               .USER_SEG_LIMIT(USER_SEG_LIMIT)) u_dec (
    .vaddr(req_vaddr), .user(req_user), .mode(mode), .base(base),
    .paddr(dec_paddr), .uncached(dec_unc), .walk(dec_walk), .fault(dec_fault)
  );

  assign req_ready = !cfg_we;
  assign accept    = req_valid && req_ready;

  logic              valid_d;
  logic [ADDR_W-1:0] paddr_d, vaddr_d;
  logic              unc_d, walk_d, fault_d;

  always_comb begin
    valid_d = accept;
    paddr_d = out_paddr;
    vaddr_d = out_vaddr;
    unc_d   = out_uncached;
    walk_d  = out_walk;
    fault_d = out_fault;
    if (accept) begin
      paddr_d = dec_paddr;
      vaddr_d = req_vaddr;
      unc_d   = dec_unc;
      walk_d  = dec_walk;
      fault_d = dec_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_paddr    <= '0;
      out_vaddr    <= '0;
      out_uncached <= 1'b0;
      out_walk     <= 1'b0;
      out_fault    <= 1'b0;
    end else if (accept) begin
      out_paddr    <= paddr_d;
      out_vaddr    <= vaddr_d;
      out_uncached <= unc_d;
      out_walk     <= walk_d;
      out_fault    <= fault_d;
    end
  end

  // R8
  blocked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !out_valid);

  // R5
  user_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_user && int'(req_vaddr[ADDR_W-1:OFF_W]) >= USER_SEG_LIMIT)
      |=> (out_valid && out_fault && !out_walk && out_paddr == '0));

  // R3
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fault && !out_walk)
      |-> (out_paddr[OFF_W-1:0] == out_vaddr[OFF_W-1:0]));

  // R4
  walk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_walk) |-> (out_paddr == '0 && !out_uncached && !out_fault));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && out_vaddr == $past(req_vaddr)));
endmodule

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_user;
  logic [31:0] req_vaddr;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        out_valid, out_uncached, out_walk, out_fault;
  logic [31:0] out_paddr, out_vaddr;

  always #4 clk = ~clk;

  seg_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_user(req_user), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .out_valid(out_valid),
    .out_paddr(out_paddr), .out_uncached(out_uncached), .out_walk(out_walk),
    .out_fault(out_fault), .out_vaddr(out_vaddr)
  );

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  // behavioural reference
  bit [15:0] m_mode;
  int        m_base [16];
  bit        e_valid, e_unc, e_walk, e_fault;
  bit [31:0] e_paddr, e_vaddr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode  = 16'h0;
      for (int i = 0; i < 16; i++) m_base[i] = i;
      e_valid = 0;
    end else begin
      int s;
      e_valid = req_valid && !cfg_we;
      if (e_valid) begin
        s       = int'(req_vaddr >> 28);
        e_vaddr = req_vaddr;
        e_fault = req_user && s >= 11;
        e_walk  = !e_fault && m_mode[s];
        e_paddr = 0;
        e_unc   = 0;
        if (!e_fault && !m_mode[s]) begin
          e_paddr = (m_base[s] << 28) | (req_vaddr & 32'h0FFF_FFFF);
          e_unc   = m_base[s] >= 8;
        end
      end
      if (cfg_we) begin
        if (cfg_sel == 2'd0) m_mode = cfg_wdata[15:0];
        else if (cfg_sel == 2'd1)
          for (int i = 0; i < 8; i++) m_base[i] = (cfg_wdata >> (4*i)) & 15;
        else if (cfg_sel == 2'd2)
          for (int i = 0; i < 8; i++) m_base[i+8] = (cfg_wdata >> (4*i)) & 15;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ok;
      checks++;
      ok = (out_valid == e_valid);
      if (ok && e_valid)
        ok = (out_paddr == e_paddr) && (out_vaddr == e_vaddr) &&
             (out_walk == e_walk) && (out_fault == e_fault) &&
             (out_uncached == e_unc);
      if (!ok) begin
        fails++;
        $display("FAIL %s: got v=%0b pa=%h va=%h w=%0b f=%0b u=%0b exp v=%0b pa=%h va=%h w=%0b f=%0b u=%0b",
                 tag, out_valid, out_paddr, out_vaddr, out_walk, out_fault, out_uncached,
                 e_valid, e_paddr, e_vaddr, e_walk, e_fault, e_unc);
      end
    end
  end

  task automatic drive(input bit v, input bit [31:0] va, input bit u,
                       input bit we, input bit [1:0] sel, input bit [31:0] wd);
    @(negedge clk);
    req_valid = v; req_vaddr = va; req_user = u;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
  endtask

  task automatic sweep(input bit u);
    for (int s = 0; s < 16; s++)
      drive(1, (32'(s) << 28) | ($urandom() & 32'h0FFF_FFFF), u, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_vaddr = 0; req_user = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: got out_valid=%b expected 0", out_valid);
    end
    rst_n = 1;
    sweep(0);                                   // R1 identity, R3, R7
    tag = "R5"; sweep(1);                       // R5 user limit on identity
    tag = "R2";
    for (int k = 0; k < 20; k++)
      drive(k % 3 != 0, $urandom(), 0, 0, 0, 0);
    tag = "R6";
    drive(0, 0, 0, 1, 2'd0, 32'h0000_27FF);     // R6 paged 0..A, D
    drive(0, 0, 0, 1, 2'd2, 32'h0804_B000);     // R6 bases B=B C=4 E=8 F=0
    drive(0, 0, 0, 1, 2'd1, 32'h0004_0000);     // R6 seg4 identity
    tag = "R4"; sweep(0);                       // R4 walks, R3/R7 linear
    tag = "R5"; sweep(1);
    tag = "R6";
    drive(0, 0, 0, 1, 2'd0, 32'h0000_0000);
    drive(1, 32'hC123_4567, 0, 0, 0, 0);        // new mode applies next cycle
    drive(1, 32'hE000_0010, 0, 0, 0, 0);        // R7 uncached base 8
    drive(1, 32'h9ABC_DEF0, 1, 0, 0, 0);        // seg9 base 0 linear
    tag = "R8";
    drive(1, 32'h4000_0000, 0, 1, 2'd1, 32'h7654_3210);
    drive(1, 32'h4000_0004, 0, 1, 2'd3, 32'hFFFF_FFFF);
    tag = "R9";
    drive(0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);     // reserved write, no effect
    sweep(0);
    sweep(1);
    tag = "R2";
    for (int k = 0; k < 40; k++)
      drive($urandom() % 2, $urandom(), $urandom() % 2, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule